// File: doc/BRIEF.md
# Vectored Daisy-Chain Interrupter

This block is the interrupt side of a bus slave board. Internal logic reports three kinds of event: a command that finished normally, a command that finished with an error, and a change of status. Each event becomes an interrupt request on one of seven priority levels, where 7 is the most urgent and 1 the least. A completion event carries the level that was programmed for its command. A status change uses a level that is set as configuration. Each event kind has its own vector. The vector is captured when the event is queued, so a handler knows what happened without reading any registers.

Events wait in a small first-in first-out queue. At most one request line is active at a time, and it carries the level of the oldest entry. The host's acknowledge cycle arrives on a serial daisy chain, with the acknowledged level on its address lines 3:1. The block claims the cycle only when a request is pending at exactly that level. In that case it asserts data acknowledge and, when vectoring is enabled, drives the vector. Otherwise it passes the acknowledge down the chain to the next board. When a claimed cycle ends, the entry leaves the queue and the next entry's level is raised.

Top module: `vec_irq_chain`

## Requirements
- R1: While reset is asserted and in the first cycle after it, irq_o is all zero and iack_out, dtack_o, data_oe and data_o are zero.
- R2: irq_o has at most one bit set. When the queue holds entries, bit L-1 is set, where L is the level of the oldest entry. When the queue is empty, irq_o is zero.
- R3: A completion event is queued with the level on cmd_lvl in that cycle. A completion event with cmd_lvl equal to 0 is discarded.
- R4: The vector queued with a completion event is vec_err when evt_err is high, even if evt_done is also high, and vec_done otherwise. A status event queues vec_stat at level stat_lvl.
- R5: An acknowledge is claimed when iack_in is sampled high while idle, an entry is pending, and iack_lvl equals that entry's level. From the next cycle dtack_o is high. It stays high until the cycle after iack_in is sampled low, and iack_out stays low throughout.
- R6: Any other acknowledge is passed on. iack_out is high from the cycle after iack_in is sampled high until the cycle after it is sampled low, and dtack_o stays low.
- R7: While a cycle is claimed with vec_en high, data_oe is 1 and data_o carries the oldest entry's vector. With vec_en low, data_oe and data_o are 0 and dtack_o is still asserted.
- R8: At the clock edge that ends a claimed cycle, the oldest entry is removed. In the same cycle, irq_o shows the next entry's level, or zero if no entry remains.
- R9: Entries are serviced in the order in which they were queued.
- R10: A status event is held until the first cycle that brings no valid completion event while the queue has room. It is queued in that cycle, after any completion events that arrived earlier or in the same cycle.
- R11: A completion event that arrives while the queue holds DEPTH entries is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_done | input | 1 | One-cycle pulse: command finished normally |
| evt_err | input | 1 | One-cycle pulse: command finished with error |
| evt_stat | input | 1 | One-cycle pulse: status change |
| cmd_lvl | input | 3 | Programmed level of the finishing command |
| stat_lvl | input | 3 | Level used for status-change interrupts |
| vec_done | input | 8 | Vector for normal completion |
| vec_err | input | 8 | Vector for error completion |
| vec_stat | input | 8 | Vector for status change |
| vec_en | input | 1 | Enables driving of the vector |
| iack_in | input | 1 | Acknowledge arriving from the upstream board |
| iack_lvl | input | 3 | Level being acknowledged (address lines 3:1) |
| irq_o | output | 7 | Request lines; bit L-1 requests level L |
| iack_out | output | 1 | Acknowledge passed to the downstream board |
| dtack_o | output | 1 | Data acknowledge for a claimed cycle |
| data_oe | output | 1 | Data bus drive enable |
| data_o | output | 8 | Vector value |

## Verification
A single pending request is acknowledged at a matching level, at a wrong level, and with nothing pending. These cases show claiming apart from passing down the chain. Events are also sent with both completion flags set, with level 0, with status changes colliding with completions, and in a burst longer than the queue. These cases show vector selection, the discard rules, the deferral of status events, and arrival order apart. Claims with vectoring off show acknowledge without data drive. A behavioural queue model checks every output on every clock.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_SERVE = 2'd1,
      CH_PASS  = 2'd2
   } chain_st_e;

endpackage

// File: rtl/vic_ingress.sv
module vic_ingress #(
   parameter int VEC_W = 8,
   parameter int LVL_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   done_i,
   input  logic                   err_i,
   input  logic                   stat_i,
   input  logic [LVL_W-1:0]       cmd_lvl_i,
   input  logic [LVL_W-1:0]       stat_lvl_i,
   input  logic [VEC_W-1:0]       vec_done_i,
   input  logic [VEC_W-1:0]       vec_err_i,
   input  logic [VEC_W-1:0]       vec_stat_i,
   input  logic                   room_i,
   output logic                   push_o,
   output logic [LVL_W+VEC_W-1:0] entry_o
);

   logic stat_pend_q;
   logic comp_ok;
   logic stat_go;

   assign comp_ok = (done_i || err_i) && (cmd_lvl_i != '0);
   assign stat_go = !comp_ok && stat_pend_q && room_i;
   assign push_o  = (comp_ok && room_i) || stat_go;

   always_comb begin
      if (comp_ok) entry_o = {cmd_lvl_i, (err_i ? vec_err_i : vec_done_i)};
      else         entry_o = {stat_lvl_i, vec_stat_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_pend_q <= 1'b0;
      else        stat_pend_q <= (stat_pend_q && !stat_go) || stat_i;
   end

endmodule

// File: rtl/vic_fifo.sv
module vic_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic         full_o,
   output logic         valid_o,
   output logic [W-1:0] head_o
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt_q;
   logic          do_push;
   logic          do_pop;

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign valid_o = (cnt_q != '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && valid_o;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (do_push) slot_q <= din_i;
         end
         assign head_o = slot_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] wr_q;
         logic [PW-1:0] rd_q;

         function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_q <= '0;
               rd_q <= '0;
            end else begin
               if (do_push) wr_q <= bump(wr_q);
               if (do_pop)  rd_q <= bump(rd_q);
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem_q[wr_q] <= din_i;
         end

         assign head_o = mem_q[rd_q];
      end
   endgenerate

endmodule

// File: rtl/vic_chain.sv
module vic_chain #(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iack_i,
   input  logic [LVL_W-1:0] iack_lvl_i,
   input  logic             pend_i,
   input  logic [LVL_W-1:0] head_lvl_i,
   output logic             serve_o,
   output logic             pass_o,
   output logic             pop_o
);

   import vic_pkg::*;

   chain_st_e st_q;
   chain_st_e st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         CH_IDLE: begin
            if (iack_i) st_d = (pend_i && (iack_lvl_i == head_lvl_i)) ? CH_SERVE : CH_PASS;
         end
         CH_SERVE: if (!iack_i) st_d = CH_IDLE;
         CH_PASS:  if (!iack_i) st_d = CH_IDLE;
         default:  st_d = CH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= CH_IDLE;
      else        st_q <= st_d;
   end

   assign serve_o = (st_q == CH_SERVE);
   assign pass_o  = (st_q == CH_PASS);
   assign pop_o   = serve_o && !iack_i;

endmodule

// File: rtl/vec_irq_chain.sv
module vec_irq_chain #(
   parameter  int VEC_W   = 8,
   parameter  int DEPTH   = 4,
   parameter  int NUM_LVL = 7,
   localparam int LVL_W   = $clog2(NUM_LVL + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_done,
   input  logic               evt_err,
   input  logic               evt_stat,
   input  logic [LVL_W-1:0]   cmd_lvl,
   input  logic [LVL_W-1:0]   stat_lvl,
   input  logic [VEC_W-1:0]   vec_done,
   input  logic [VEC_W-1:0]   vec_err,
   input  logic [VEC_W-1:0]   vec_stat,
   input  logic               vec_en,
   input  logic               iack_in,
   input  logic [LVL_W-1:0]   iack_lvl,
   output logic [NUM_LVL-1:0] irq_o,
   output logic               iack_out,
   output logic               dtack_o,
   output logic               data_oe,
   output logic [VEC_W-1:0]   data_o
);

   localparam int EW = LVL_W + VEC_W;

   if (DEPTH < 1)   $error("DEPTH must be at least 1");
   if (VEC_W < 1)   $error("VEC_W must be at least 1");
   if (NUM_LVL < 1) $error("NUM_LVL must be at least 1");

   logic          push;
   logic [EW-1:0] entry;
   logic          full;
   logic          pend;
   logic [EW-1:0] head;
   logic          serve;
   logic          pop;
   logic [LVL_W-1:0] head_lvl;
   logic [VEC_W-1:0] head_vec;

   assign head_lvl = head[EW-1:VEC_W];
   assign head_vec = head[VEC_W-1:0];

   vic_ingress #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_ingress (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (evt_done),
      .err_i      (evt_err),
      .stat_i     (evt_stat),
      .cmd_lvl_i  (cmd_lvl),
      .stat_lvl_i (stat_lvl),
      .vec_done_i (vec_done),
      .vec_err_i  (vec_err),
      .vec_stat_i (vec_stat),
      .room_i     (!full),
      .push_o     (push),
      .entry_o    (entry)
   );

   vic_fifo #(.W(EW), .DEPTH(DEPTH)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .din_i   (entry),
      .pop_i   (pop),
      .full_o  (full),
      .valid_o (pend),
      .head_o  (head)
   );

   vic_chain #(.LVL_W(LVL_W)) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .iack_i     (iack_in),
      .iack_lvl_i (iack_lvl),
      .pend_i     (pend),
      .head_lvl_i (head_lvl),
      .serve_o    (serve),
      .pass_o     (iack_out),
      .pop_o      (pop)
   );

   for (genvar l = 1; l <= NUM_LVL; l++) begin : g_irq
      assign irq_o[l-1] = pend && (head_lvl == LVL_W'(l));
   end

   assign dtack_o = serve;
   assign data_oe = serve && vec_en;
   assign data_o  = data_oe ? head_vec : '0;

endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
   parameter int NUM_LVL = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               iack_in,
   input logic [NUM_LVL-1:0] irq_o,
   input logic               iack_out,
   input logic               dtack_o,
   input logic               data_oe
);

   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_o));

   p_claim_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dtack_o) |-> $past(iack_in));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dtack_o && iack_in) |=> dtack_o);

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(dtack_o && iack_out));

   p_pass_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_out && !iack_in) |=> !iack_out);

   p_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> dtack_o);

   p_irq_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dtack_o |-> $stable(irq_o));

endmodule

bind vec_irq_chain vic_chk #(.NUM_LVL(NUM_LVL)) u_vic_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iack_in  (iack_in),
   .irq_o    (irq_o),
   .iack_out (iack_out),
   .dtack_o  (dtack_o),
   .data_oe  (data_oe)
);

// File: tb/vec_irq_chain_tb_top.sv
`timescale 1ns/1ps
module vec_irq_chain_tb_top;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_done = 1'b0, evt_err = 1'b0, evt_stat = 1'b0;
   logic [2:0] cmd_lvl = '0, stat_lvl = 3'd6, iack_lvl = '0;
   logic [7:0] vec_done = 8'hA1, vec_err = 8'hE7, vec_stat = 8'h5C;
   logic       vec_en = 1'b1, iack_in = 1'b0;
   logic [6:0] irq_o;
   logic       iack_out, dtack_o, data_oe;
   logic [7:0] data_o;

   int tests = 0;
   int fails = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   vec_irq_chain dut_i (
      .clk(clk), .rst_n(rst_n), .evt_done(evt_done), .evt_err(evt_err), .evt_stat(evt_stat),
      .cmd_lvl(cmd_lvl), .stat_lvl(stat_lvl), .vec_done(vec_done), .vec_err(vec_err),
      .vec_stat(vec_stat), .vec_en(vec_en), .iack_in(iack_in), .iack_lvl(iack_lvl),
      .irq_o(irq_o), .iack_out(iack_out), .dtack_o(dtack_o), .data_oe(data_oe), .data_o(data_o)
   );

   task automatic chk(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int  m_lvl[$];
   int  m_vec[$];
   int  m_st = 0;      // 0 idle, 1 claimed, 2 passing
   bit  m_spend = 0;
   bit  m_live = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lvl.delete(); m_vec.delete(); m_st = 0; m_spend = 0;
      end else begin
         int  n;
         bit  pop, comp, sgo;
         n = m_lvl.size();
         pop = (m_st == 1) && !iack_in;
         case (m_st)
            0: if (iack_in) m_st = (n > 0 && int'(iack_lvl) == m_lvl[0]) ? 1 : 2;
            default: if (!iack_in) m_st = 0;
         endcase
         comp = (evt_done || evt_err) && cmd_lvl != 0;
         sgo  = !comp && m_spend && n < DEPTH;
         if (comp && n < DEPTH) begin
            m_lvl.push_back(int'(cmd_lvl));
            m_vec.push_back(evt_err ? int'(vec_err) : int'(vec_done));
         end else if (sgo) begin
            m_lvl.push_back(int'(stat_lvl));
            m_vec.push_back(int'(vec_stat));
         end
         m_spend = (m_spend && !sgo) || evt_stat;
         if (pop) begin
            void'(m_lvl.pop_front());
            void'(m_vec.pop_front());
         end
      end
      #1;
      if (m_live && !done_flag) begin
         int eirq, eoe;
         eirq = (m_lvl.size() > 0) ? (1 << (m_lvl[0] - 1)) : 0;
         eoe  = (m_st == 1 && vec_en) ? 1 : 0;
         chk("R2 irq_o", int'(irq_o), eirq);
         chk("R5 dtack_o", int'(dtack_o), (m_st == 1) ? 1 : 0);
         chk("R6 iack_out", int'(iack_out), (m_st == 2) ? 1 : 0);
         chk("R7 data_oe", int'(data_oe), eoe);
         chk("R7 data_o", int'(data_o), eoe ? m_vec[0] : 0);
      end
   end

   task automatic ev(bit d, bit e, bit s, int lvl, int vd);
      @(negedge clk);
      evt_done = d; evt_err = e; evt_stat = s; cmd_lvl = 3'(lvl); vec_done = 8'(vd);
      @(negedge clk);
      evt_done = 0; evt_err = 0; evt_stat = 0;
   endtask

   task automatic claim(int lvl, int vec, bit oe, string tag);
      @(negedge clk); iack_in = 1; iack_lvl = 3'(lvl);
      @(posedge clk); #1;
      chk(tag, int'(dtack_o), 1);
      chk(tag, int'(iack_out), 0);
      chk(tag, int'(data_oe), int'(oe));
      chk(tag, int'(data_o), oe ? vec : 0);
      @(negedge clk); iack_in = 0;
      @(posedge clk); #1;
      chk(tag, int'(dtack_o), 0);
   endtask

   task automatic pass_on(int lvl, string tag);
      @(negedge clk); iack_in = 1; iack_lvl = 3'(lvl);
      @(posedge clk); #1;
      chk(tag, int'(iack_out), 1);
      chk(tag, int'(dtack_o), 0);
      @(negedge clk); iack_in = 0;
      @(posedge clk); #1;
      chk(tag, int'(iack_out), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 irq", int'(irq_o), 0);
      chk("R1 ack", int'({iack_out, dtack_o, data_oe}), 0);
      chk("R1 data", int'(data_o), 0);
      @(negedge clk); rst_n = 1; m_live = 1;
      @(posedge clk); #1;
      chk("R1 irq after", int'(irq_o), 0);

      // R6: nothing pending, acknowledge passes
      pass_on(3, "R6 empty");

      // R3: normal completion at level 3
      ev(1, 0, 0, 3, 8'hA1);
      chk("R3 lvl3", int'(irq_o), 7'b0000100);
      claim(3, 8'hA1, 1, "R3 claim");
      chk("R8 empty", int'(irq_o), 0);

      // R3: level 0 discarded
      ev(1, 0, 0, 0, 8'hA1);
      repeat (2) @(posedge clk);
      #1 chk("R3 lvl0", int'(irq_o), 0);

      // R4/R6: error at level 5, wrong-level IACK passes
      ev(0, 1, 0, 5, 8'hA1);
      pass_on(2, "R6 wrong level");
      chk("R6 still pending", int'(irq_o), 7'b0010000);
      claim(5, 8'hE7, 1, "R4 err vec");

      // R4: both flags -> error vector; level 7
      ev(1, 1, 0, 7, 8'hA1);
      claim(7, 8'hE7, 1, "R4 both");

      // R7: vectoring off
      @(negedge clk); vec_en = 0;
      ev(1, 0, 0, 1, 8'h11);
      claim(1, 8'h11, 0, "R7 no drive");
      @(negedge clk); vec_en = 1;

      // R9/R10: status collides with completions
      @(negedge clk);
      evt_done = 1; cmd_lvl = 3'd2; vec_done = 8'h21; evt_stat = 1;
      @(negedge clk);
      evt_stat = 0; vec_done = 8'h22;
      @(negedge clk);
      evt_done = 0;
      claim(2, 8'h21, 1, "R9 first");
      chk("R8 next lvl2", int'(irq_o), 7'b0000010);
      claim(2, 8'h22, 1, "R9 second");
      chk("R8 next lvl6", int'(irq_o), 7'b0100000);
      claim(6, 8'h5C, 1, "R10 status");

      // R11: burst of DEPTH+1 completions
      for (int i = 0; i <= DEPTH; i++) begin
         @(negedge clk);
         evt_done = 1; cmd_lvl = 3'd3; vec_done = 8'(8'h30 + i);
      end
      @(negedge clk); evt_done = 0;
      for (int i = 0; i < DEPTH; i++) claim(3, 8'h30 + i, 1, "R11 drain");
      repeat (2) @(posedge clk);
      #1 chk("R11 dropped", int'(irq_o), 0);

      repeat (3) @(posedge clk);
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule